// File: doc/BRIEF.md
# Per-Stream Token-Bucket Admission Policer

This block polices frame admission for up to sixteen streams. Each frame descriptor carries a stream number and a byte length. For every stream the block keeps a token bucket counted in bytes. When a descriptor arrives, the bucket is topped up for the cycles that have passed since that stream's previous arrival. The descriptor is then judged conforming or violating. Conforming frames always pass. For a violating frame, the stream's configured reaction decides what happens: let it through, drop it, or mark it.

Every descriptor comes out on a valid/ready output, in arrival order, with its verdict attached. A downstream frame buffer uses the verdict to discard or tag the frame. The per-stream rate, burst ceiling and violation reaction are static configuration inputs.

Per-stream audit counters make the cost of policing visible. They record how many frames violated, were dropped and were marked, the longest completed violation episode, and the worst byte deficit. A select input reads the counters for one stream.

Top module: `stream_policer`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or `out_ready` is high. A descriptor is taken on a rising edge with `in_valid` and `in_ready` both high. Each taken descriptor appears exactly once on the output, in order, with the same `out_sid` and `out_len`. While `out_valid` is high and `out_ready` is low, the output holds steady. After reset, `out_valid` is low and `in_ready` is high.
- R2: A cycle counter is cleared while `rst_n` is low and advances by one on every later rising edge. A descriptor's arrival time is the counter value at the edge that takes it. At reset every bucket holds zero tokens and has a reference time of zero. On each arrival, the bucket gains rate × (arrival time − reference time) bytes, is capped at the stream's burst ceiling, and takes the arrival time as its new reference time. The rate of stream s is `cfg_rate[8s+7:8s]` in bytes per cycle. Its burst ceiling is `cfg_burst[16s+15:16s]` in bytes.
- R3: A frame conforms when the refilled token count is at least its length. A conforming frame removes its length from the bucket. A violating frame removes nothing. `out_conf` is 1 for a conforming frame and 0 for a violating one.
- R4: `out_act` reports the applied action: 0 = pass, 1 = drop, 2 = mark. A conforming frame always reports 0. A violating frame of stream s reports the code in `cfg_act[2s+1:2s]`, except that code 3 is treated as 0. Dropped frames still appear on the output, so that the buffer can discard them.
- R5: Two descriptors for the same stream taken on consecutive edges are judged as if the first one had fully updated that stream's bucket before the second arrived.
- R6: For each stream, the violation counter counts violating frames. The drop counter counts violating frames with action 1. The mark counter counts violating frames with action 2.
- R7: A violation episode opens at the arrival of a violating frame when no episode is open. It closes at the arrival of the stream's next conforming frame. Its length is the difference between those two arrival times. The duration counter keeps the longest closed episode and is zero at reset.
- R8: The peak counter keeps, per stream, the largest deficit (frame length minus refilled tokens) seen on any violating frame. It is zero at reset.
- R9: `stat_viol`, `stat_drop`, `stat_mark`, `stat_dur` and `stat_peak` show the counters of stream `stat_sel` in the same cycle. All counters read zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken |
| in_sid | input | 4 | Stream number of the offered descriptor |
| in_len | input | 14 | Frame length in bytes |
| out_valid | output | 1 | Judged descriptor available |
| out_ready | input | 1 | Downstream takes the judged descriptor |
| out_sid | output | 4 | Stream number of the judged descriptor |
| out_len | output | 14 | Frame length of the judged descriptor |
| out_conf | output | 1 | 1 = conforming, 0 = violating |
| out_act | output | 2 | Applied action: 0 pass, 1 drop, 2 mark |
| cfg_rate | input | 128 | Per-stream refill rate in bytes per cycle, 8 bits per stream |
| cfg_burst | input | 256 | Per-stream burst ceiling in bytes, 16 bits per stream |
| cfg_act | input | 32 | Per-stream violation reaction, 2 bits per stream |
| stat_sel | input | 4 | Stream whose counters are shown |
| stat_viol | output | 16 | Violating frames of the selected stream |
| stat_drop | output | 16 | Dropped frames of the selected stream |
| stat_mark | output | 16 | Marked frames of the selected stream |
| stat_dur | output | 32 | Longest closed violation episode, in cycles |
| stat_peak | output | 14 | Largest deficit in bytes |

## Verification
On every cycle, the assertions check four things. The output must hold while stalled. A conforming verdict must always carry the pass action. A written bucket must never exceed its ceiling. A back-to-back snapshot must pick up the value written at the same edge. They also check that drops plus marks never exceed violations for the shown stream.

Only the bench scenarios can show the rest. These are the refill arithmetic against arrival times, the exact-equality boundary of the conformance test, the opening and closing of episodes and their longest length, and the worst deficit. The bench uses directed cases (an empty bucket with no refill, exact token equality, back-to-back bursts to one stream) mixed with seeded random traffic under output backpressure.

// File: rtl/policer_pkg.sv
package policer_pkg;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_DROP = 2'd1,
    ACT_MARK = 2'd2,
    ACT_RSVD = 2'd3
  } act_e;

  // Top up a bucket by rate * elapsed, limited by the ceiling.
  function automatic logic [63:0] bucket_refill(input logic [63:0] tok,
                                                input logic [63:0] rate,
                                                input logic [63:0] elapsed,
                                                input logic [63:0] cap);
    logic [63:0] sum;
    sum = tok + rate * elapsed;
    return (sum > cap) ? cap : sum;
  endfunction

  // Conformance: enough tokens to cover the whole frame.
  function automatic logic frame_fits(input logic [63:0] tok, input logic [63:0] len);
    return tok >= len;
  endfunction

  // Action actually applied; reserved code behaves as pass.
  function automatic act_e resolve_act(input logic conf, input logic [1:0] code);
    if (conf) return ACT_PASS;
    case (code)
      2'd1:    return ACT_DROP;
      2'd2:    return ACT_MARK;
      default: return ACT_PASS;
    endcase
  endfunction

endpackage

// File: rtl/pol_bucket_store.sv
module pol_bucket_store #(
  parameter int N_STREAMS = 16,
  parameter int TOK_W     = 16,
  parameter int TS_W      = 32,
  localparam int SID_W    = $clog2(N_STREAMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SID_W-1:0] rd_sid,
  input  logic             wr_en,
  input  logic [SID_W-1:0] wr_sid,
  input  logic [TOK_W-1:0] wr_tok,
  input  logic [TS_W-1:0]  wr_ts,
  output logic [TOK_W-1:0] snap_tok,
  output logic [TS_W-1:0]  snap_ts
);

  logic [TOK_W-1:0] tok_q [N_STREAMS];
  logic [TS_W-1:0]  ts_q  [N_STREAMS];
  logic             byp;

  // Same stream read while its update lands: forward the update.
  assign byp = rd_en && wr_en && (rd_sid == wr_sid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_STREAMS; i++) begin
        tok_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else if (wr_en) begin
      tok_q[wr_sid] <= wr_tok;
      ts_q[wr_sid]  <= wr_ts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_tok <= '0;
      snap_ts  <= '0;
    end else if (rd_en) begin
      snap_tok <= byp ? wr_tok : tok_q[rd_sid];
      snap_ts  <= byp ? wr_ts  : ts_q[rd_sid];
    end
  end

  // R5
  bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> (snap_tok == $past(wr_tok)) && (snap_ts == $past(wr_ts)));

endmodule

// File: rtl/pol_meter.sv
module pol_meter import policer_pkg::*; #(
  parameter int LEN_W  = 14,
  parameter int RATE_W = 8,
  parameter int TOK_W  = 16,
  parameter int TS_W   = 32
) (
  input  logic [TOK_W-1:0]  snap_tok,
  input  logic [TS_W-1:0]   snap_ts,
  input  logic [TS_W-1:0]   cur_ts,
  input  logic [LEN_W-1:0]  len,
  input  logic [RATE_W-1:0] rate,
  input  logic [TOK_W-1:0]  burst,
  output logic              conf,
  output logic [TOK_W-1:0]  new_tok,
  output logic [LEN_W-1:0]  deficit
);

  logic [TS_W-1:0]  elapsed;
  logic [TOK_W-1:0] avail;

  assign elapsed = cur_ts - snap_ts;
  assign avail   = TOK_W'(bucket_refill(64'(snap_tok), 64'(rate), 64'(elapsed), 64'(burst)));
  assign conf    = frame_fits(64'(avail), 64'(len));
  assign new_tok = conf ? (avail - TOK_W'(len)) : avail;
  assign deficit = conf ? '0 : LEN_W'(TOK_W'(len) - avail);

endmodule

// File: rtl/pol_audit.sv
module pol_audit import policer_pkg::*; #(
  parameter int N_STREAMS = 16,
  parameter int LEN_W     = 14,
  parameter int TS_W      = 32,
  parameter int CNT_W     = 16,
  localparam int SID_W    = $clog2(N_STREAMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [SID_W-1:0] upd_sid,
  input  logic             upd_conf,
  input  act_e             upd_act,
  input  logic [LEN_W-1:0] upd_deficit,
  input  logic [TS_W-1:0]  upd_ts,
  input  logic [SID_W-1:0] stat_sel,
  output logic [CNT_W-1:0] stat_viol,
  output logic [CNT_W-1:0] stat_drop,
  output logic [CNT_W-1:0] stat_mark,
  output logic [TS_W-1:0]  stat_dur,
  output logic [LEN_W-1:0] stat_peak
);

  logic [CNT_W-1:0] viol_v [N_STREAMS];
  logic [CNT_W-1:0] drop_v [N_STREAMS];
  logic [CNT_W-1:0] mark_v [N_STREAMS];
  logic [TS_W-1:0]  dur_v  [N_STREAMS];
  logic [LEN_W-1:0] peak_v [N_STREAMS];

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_stream
    logic             hit;
    logic             open_q;
    logic [TS_W-1:0]  start_q;
    logic [TS_W-1:0]  ep_len;
    logic [CNT_W-1:0] viol_q, drop_q, mark_q;
    logic [TS_W-1:0]  dur_q;
    logic [LEN_W-1:0] peak_q;

    assign hit    = upd_en && (upd_sid == SID_W'(g));
    assign ep_len = upd_ts - start_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q  <= 1'b0;
        start_q <= '0;
        viol_q  <= '0;
        drop_q  <= '0;
        mark_q  <= '0;
        dur_q   <= '0;
        peak_q  <= '0;
      end else if (hit) begin
        if (upd_conf) begin
          if (open_q) begin
            open_q <= 1'b0;
            if (ep_len > dur_q) dur_q <= ep_len;
          end
        end else begin
          viol_q <= viol_q + 1'b1;
          if (upd_act == ACT_DROP) drop_q <= drop_q + 1'b1;
          if (upd_act == ACT_MARK) mark_q <= mark_q + 1'b1;
          if (!open_q) begin
            open_q  <= 1'b1;
            start_q <= upd_ts;
          end
          if (upd_deficit > peak_q) peak_q <= upd_deficit;
        end
      end
    end

    assign viol_v[g] = viol_q;
    assign drop_v[g] = drop_q;
    assign mark_v[g] = mark_q;
    assign dur_v[g]  = dur_q;
    assign peak_v[g] = peak_q;
  end

  assign stat_viol = viol_v[stat_sel];
  assign stat_drop = drop_v[stat_sel];
  assign stat_mark = mark_v[stat_sel];
  assign stat_dur  = dur_v[stat_sel];
  assign stat_peak = peak_v[stat_sel];

  // R6
  tally_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, stat_drop} + {1'b0, stat_mark}) <= {1'b0, stat_viol});

endmodule

// File: rtl/stream_policer.sv
module stream_policer import policer_pkg::*; #(
  parameter int N_STREAMS = 16,
  parameter int LEN_W     = 14,
  parameter int RATE_W    = 8,
  parameter int TOK_W     = 16,
  parameter int TS_W      = 32,
  parameter int CNT_W     = 16,
  localparam int SID_W    = $clog2(N_STREAMS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SID_W-1:0]            in_sid,
  input  logic [LEN_W-1:0]            in_len,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [SID_W-1:0]            out_sid,
  output logic [LEN_W-1:0]            out_len,
  output logic                        out_conf,
  output logic [1:0]                  out_act,
  input  logic [N_STREAMS*RATE_W-1:0] cfg_rate,
  input  logic [N_STREAMS*TOK_W-1:0]  cfg_burst,
  input  logic [N_STREAMS*2-1:0]      cfg_act,
  input  logic [SID_W-1:0]            stat_sel,
  output logic [CNT_W-1:0]            stat_viol,
  output logic [CNT_W-1:0]            stat_drop,
  output logic [CNT_W-1:0]            stat_mark,
  output logic [TS_W-1:0]             stat_dur,
  output logic [LEN_W-1:0]            stat_peak
);

  logic [TS_W-1:0]   ts_q;
  logic              adv, acc, wr_en;
  logic              a_valid;
  logic [SID_W-1:0]  a_sid;
  logic [LEN_W-1:0]  a_len;
  logic [TS_W-1:0]   a_ts;
  logic [RATE_W-1:0] rate_tab  [N_STREAMS];
  logic [TOK_W-1:0]  burst_tab [N_STREAMS];
  logic [1:0]        code_tab  [N_STREAMS];
  logic [TOK_W-1:0]  snap_tok;
  logic [TS_W-1:0]   snap_ts;
  logic              m_conf;
  logic [TOK_W-1:0]  m_tok;
  logic [LEN_W-1:0]  m_def;
  act_e              m_act;

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_cfg
    assign rate_tab[g]  = cfg_rate[g*RATE_W +: RATE_W];
    assign burst_tab[g] = cfg_burst[g*TOK_W +: TOK_W];
    assign code_tab[g]  = cfg_act[g*2 +: 2];
  end

  // Whole pipe moves together when the output slot frees up.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign acc      = in_valid && adv;
  assign wr_en    = a_valid && adv;
  assign m_act    = resolve_act(m_conf, code_tab[a_sid]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_sid   <= '0;
      a_len   <= '0;
      a_ts    <= '0;
    end else if (adv) begin
      a_valid <= in_valid;
      if (acc) begin
        a_sid <= in_sid;
        a_len <= in_len;
        a_ts  <= ts_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sid   <= '0;
      out_len   <= '0;
      out_conf  <= 1'b0;
      out_act   <= 2'd0;
    end else if (adv) begin
      out_valid <= a_valid;
      if (a_valid) begin
        out_sid  <= a_sid;
        out_len  <= a_len;
        out_conf <= m_conf;
        out_act  <= m_act;
      end
    end
  end

  pol_bucket_store #(.N_STREAMS(N_STREAMS), .TOK_W(TOK_W), .TS_W(TS_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_en(acc), .rd_sid(in_sid),
    .wr_en(wr_en), .wr_sid(a_sid), .wr_tok(m_tok), .wr_ts(a_ts),
    .snap_tok(snap_tok), .snap_ts(snap_ts)
  );

  pol_meter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .TOK_W(TOK_W), .TS_W(TS_W)) u_meter (
    .snap_tok(snap_tok), .snap_ts(snap_ts), .cur_ts(a_ts), .len(a_len),
    .rate(rate_tab[a_sid]), .burst(burst_tab[a_sid]),
    .conf(m_conf), .new_tok(m_tok), .deficit(m_def)
  );

  pol_audit #(.N_STREAMS(N_STREAMS), .LEN_W(LEN_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_audit (
    .clk(clk), .rst_n(rst_n),
    .upd_en(wr_en), .upd_sid(a_sid), .upd_conf(m_conf), .upd_act(m_act),
    .upd_deficit(m_def), .upd_ts(a_ts), .stat_sel(stat_sel),
    .stat_viol(stat_viol), .stat_drop(stat_drop), .stat_mark(stat_mark),
    .stat_dur(stat_dur), .stat_peak(stat_peak)
  );

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sid) && $stable(out_len)
                                  && $stable(out_conf) && $stable(out_act));

  // R4
  conform_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_conf) |-> (out_act == 2'd0));

  // R2
  bucket_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (m_tok <= burst_tab[a_sid]));

endmodule

// File: tb/stream_policer_test.sv
`timescale 1ns/1ps
module stream_policer_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_sid = '0;
  logic [13:0]  in_len = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [3:0]   out_sid;
  logic [13:0]  out_len;
  logic         out_conf;
  logic [1:0]   out_act;
  logic [127:0] cfg_rate = '0;
  logic [255:0] cfg_burst = '0;
  logic [31:0]  cfg_act = '0;
  logic [3:0]   stat_sel = '0;
  logic [15:0]  stat_viol, stat_drop, stat_mark;
  logic [31:0]  stat_dur;
  logic [13:0]  stat_peak;

  always #4 clk = ~clk;

  stream_policer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sid(in_sid), .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_sid(out_sid), .out_len(out_len), .out_conf(out_conf), .out_act(out_act),
    .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .cfg_act(cfg_act), .stat_sel(stat_sel),
    .stat_viol(stat_viol), .stat_drop(stat_drop), .stat_mark(stat_mark),
    .stat_dur(stat_dur), .stat_peak(stat_peak)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit bp_mode = 0;
  longint tsc;

  always @(posedge clk) begin
    if (!rst_n) tsc <= 0;
    else        tsc <= tsc + 1;
  end

  // configuration and reference state
  longint r_rate [16], r_burst [16], r_code [16];
  longint m_tok [16], m_ts [16], m_start [16];
  longint m_viol [16], m_drop [16], m_mark [16], m_dur [16], m_peak [16];
  bit     m_open [16];
  int     e_sid [1024], e_len [1024], e_conf [1024], e_act [1024];
  int     wr_i = 0, rd_i = 0;

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference policer applied at arrival time ts
  task automatic model_frame(input int s, input int len, input longint ts);
    longint t;
    int conf, act;
    t = m_tok[s] + r_rate[s] * (ts - m_ts[s]);
    if (t > r_burst[s]) t = r_burst[s];
    conf = (t >= len) ? 1 : 0;
    m_ts[s] = ts;
    if (conf == 1) begin
      m_tok[s] = t - len;
      act = 0;
      if (m_open[s]) begin
        if (ts - m_start[s] > m_dur[s]) m_dur[s] = ts - m_start[s];
        m_open[s] = 0;
      end
    end else begin
      m_tok[s] = t;
      act = (r_code[s] == 1) ? 1 : (r_code[s] == 2) ? 2 : 0;
      m_viol[s]++;
      if (act == 1) m_drop[s]++;
      if (act == 2) m_mark[s]++;
      if (!m_open[s]) begin
        m_open[s] = 1;
        m_start[s] = ts;
      end
      if (len - t > m_peak[s]) m_peak[s] = len - t;
    end
    e_sid[wr_i] = s; e_len[wr_i] = len; e_conf[wr_i] = conf; e_act[wr_i] = act;
    wr_i++;
  endtask

  task automatic send(input int s, input int len);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_sid   = 4'(s);
    in_len   = 14'(len);
    do @(negedge clk); while (!in_ready);
    model_frame(s, len, tsc);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  // downstream readiness
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rd_i == wr_i) check_eq("R1 output without input", 1, 0);
      else begin
        check_eq($sformatf("R1 sid of output %0d", rd_i), out_sid, e_sid[rd_i]);
        check_eq($sformatf("R1 len of output %0d", rd_i), out_len, e_len[rd_i]);
        check_eq($sformatf("R3 verdict of output %0d", rd_i), out_conf, e_conf[rd_i]);
        check_eq($sformatf("R4 action of output %0d", rd_i), out_act, e_act[rd_i]);
        rd_i++;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 16; s++) begin
      r_rate[s]  = 1 + ($urandom % 12);
      r_burst[s] = 200 + ($urandom % 1800);
      r_code[s]  = $urandom % 4;
      m_tok[s] = 0; m_ts[s] = 0; m_start[s] = 0; m_open[s] = 0;
      m_viol[s] = 0; m_drop[s] = 0; m_mark[s] = 0; m_dur[s] = 0; m_peak[s] = 0;
    end
    r_rate[0] = 0; r_burst[0] = 1000; r_code[0] = 1;   // never refills, drops
    r_rate[1] = 1; r_burst[1] = 100;  r_code[1] = 0;   // equality corner
    r_rate[2] = 3; r_burst[2] = 600;  r_code[2] = 2;   // marks
    r_rate[3] = 2; r_burst[3] = 500;  r_code[3] = 3;   // reserved code
    for (int s = 0; s < 16; s++) begin
      cfg_rate[s*8 +: 8]    = 8'(r_rate[s]);
      cfg_burst[s*16 +: 16] = 16'(r_burst[s]);
      cfg_act[s*2 +: 2]     = 2'(r_code[s]);
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 out_valid after reset", out_valid, 0);
    check_eq("R1 in_ready after reset", in_ready, 1);
    // R9 counters clear
    check_eq("R9 viol after reset", stat_viol, 0);
    check_eq("R9 peak after reset", stat_peak, 0);

    idle(150);
    // R3 exact equality: 100 tokens vs 100 bytes, then 1 token vs 1 byte
    send(1, 100);
    send(1, 1);
    send(1, 5);       // violates, pass action
    idle(20);
    send(1, 5);       // closes episode (R7)
    // R4 drop on empty bucket, R8 deficit
    send(0, 64);
    send(0, 300);
    // R5 back-to-back to one stream
    for (int k = 0; k < 8; k++) send(5, 60 + 20 * k);
    for (int k = 0; k < 6; k++) send(2, 250);
    idle(40);
    send(2, 100);
    send(3, 900);
    idle(10);
    // random traffic, half under backpressure
    for (int k = 0; k < 500; k++) begin
      bp_mode = (k >= 250);
      send($urandom % 16, 40 + ($urandom % 860));
      if (($urandom % 4) == 0) idle($urandom % 30);
    end
    bp_mode = 0;
    idle(5);
    while (rd_i != wr_i) @(negedge clk);
    check_eq("R1 all outputs delivered", rd_i, wr_i);

    for (int s = 0; s < 16; s++) begin
      @(posedge clk); #1 stat_sel = 4'(s);
      @(negedge clk);
      check_eq($sformatf("R6 violations s%0d", s), stat_viol, m_viol[s]);
      check_eq($sformatf("R6 drops s%0d", s), stat_drop, m_drop[s]);
      check_eq($sformatf("R6 marks s%0d", s), stat_mark, m_mark[s]);
      check_eq($sformatf("R7 episode s%0d", s), stat_dur, m_dur[s]);
      check_eq($sformatf("R8 peak s%0d", s), stat_peak, m_peak[s]);
      check_eq($sformatf("R9 read select s%0d", s), stat_sel, s);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual %0d expected %0d outputs", rd_i, wr_i);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule